// File: doc/BRIEF.md
# Parallel Host MIDI Port

This block lets a host processor exchange MIDI bytes with a synthesizer core over an 8-bit parallel register interface. The host sees two registers behind one address bit: a data register and a status/control register. Writes to the data register are passed to the synthesizer as MIDI bytes over a one-entry valid/ready stream. Writes to the control register carry commands: one returns the port to its power-up routing, the other hands the serial MIDI input over to the host.

A built-in receiver deserializes the serial MIDI line (31250 baud, 8 data bits, no parity, 1 stop bit). In the default routing, called intelligent mode, received bytes go to the synthesizer stream. In UART mode they land in the host data register instead. An interrupt output then rises, and it drops once the host reads that register. Host strobes are asynchronous to the block clock. They pass through synchronizers, and each transfer takes effect when its strobe is released.

Top module: `midi_host_port`

## Requirements
- R1: After reset the status register reads 0x7F, the interrupt output is low, the overrun flag is low, the synthesizer stream is empty and the port is in intelligent mode.
- R2: The read data enable is high only while select and read strobe are both low. With register select 0 the data register is presented; with register select 1 the status byte is presented, where bit 7 = 1 means the stream holding slot is occupied, bit 6 = 0 means a byte waits for the host, and bits 5..0 read 1.
- R3: A write takes effect when its strobe rises while select is low, and a strobe with select high has no effect. With register select 0 the byte is offered to the synthesizer stream in either mode.
- R4: Control byte 0xFF, in either mode, returns the port to intelligent mode and clears the overrun flag. It also loads 0xFE into the data register and marks it as available.
- R5: Control byte 0x3F in intelligent mode enters UART mode and leaves 0xFE available in the data register. In UART mode every control byte except 0xFF is ignored. In intelligent mode every control byte other than 0xFF and 0x3F is ignored.
- R6: A completed read with register select 0 clears the available flag and drops the interrupt. A read of the status register leaves both unchanged.
- R7: The receiver samples at 16 times the baud rate and takes bits LSB first. It rechecks the start bit at mid-bit and ignores a low pulse shorter than half a bit. It drops a frame whose stop bit is low and waits for the line to return high before looking for the next start bit.
- R8: In intelligent mode a received byte goes to the synthesizer stream. It does not touch the data register and does not raise the interrupt.
- R9: In UART mode a received byte is written into the data register, the available flag is set and the interrupt rises.
- R10: In UART mode a byte that arrives while the previous one is unread overwrites it and sets the overrun flag. The flag stays set until a 0xFF command or a hardware reset clears it.
- R11: The stream holds one byte and keeps valid and data stable until ready is seen. A host byte or received byte that arrives while the slot is occupied is dropped. If both arrive in the same cycle into an empty slot, the host byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_n | input | 1 | Host select, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_reg_sel | input | 1 | 0 = data register, 1 = status (read) / control (write) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| bus_rdata_oe | output | 1 | High while the read data should be driven onto the bus |
| host_int | output | 1 | Interrupt: a received byte waits in the data register |
| midi_rxd | input | 1 | Serial MIDI input, idle high |
| syn_valid | output | 1 | Byte for the synthesizer is valid |
| syn_data | output | 8 | Byte for the synthesizer |
| syn_ready | input | 1 | Synthesizer accepts the byte |
| rx_overrun | output | 1 | Sticky flag: an unread host byte was overwritten |

## Verification
The hardest case to reach is the overrun in UART mode. It needs a command to change the routing first, then two complete serial frames with no data register read between them, then a read that must clear the interrupt but leave the sticky flag set. The bench drives the serial line bit by bit at the configured baud rate, with a reduced clock-to-baud ratio so that whole frames fit in the run. It orders the command, both frames and the reads so that each condition is established before the next step. Framing errors and sub-half-bit glitches come from the same serial task, using a forced low stop bit or a short low pulse.

// File: rtl/mhp_pkg.sv
package mhp_pkg;

  localparam int unsigned MIDI_W = 8;

  localparam logic [MIDI_W-1:0] CMD_RESET = 8'hFF;
  localparam logic [MIDI_W-1:0] CMD_UART  = 8'h3F;
  localparam logic [MIDI_W-1:0] ACK_BYTE  = 8'hFE;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT
  } rx_state_e;

  // Clock cycles per oversampling tick, never below one.
  function automatic int unsigned baud_div(int unsigned clk_hz, int unsigned baud,
                                           int unsigned os);
    int unsigned d;
    d = clk_hz / (baud * os);
    return (d == 0) ? 1 : d;
  endfunction

  // Status byte: bit 7 = stream slot busy, bit 6 = no byte for host, rest 1.
  function automatic logic [MIDI_W-1:0] status_byte(logic slot_full, logic host_avail);
    return {slot_full, ~host_avail, 6'b111111};
  endfunction

endpackage

// File: rtl/mhp_strobe_sync.sv
module mhp_strobe_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_i,
  input  logic [W-1:0] pay_i,
  output logic         end_o,
  output logic [W-1:0] pay_o
);

  logic [STAGES:0] act_q;
  logic [W-1:0]    pay_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      for (int i = 0; i < int'(STAGES); i++) pay_q[i] <= '0;
    end else begin
      act_q <= {act_q[STAGES-1:0], act_i};
      pay_q[0] <= pay_i;
      for (int i = 1; i < int'(STAGES); i++) pay_q[i] <= pay_q[i-1];
    end
  end

  // Strobe release: active last cycle, inactive now.
  assign end_o = act_q[STAGES] & ~act_q[STAGES-1];
  assign pay_o = pay_q[STAGES-1];

endmodule

// File: rtl/mhp_serial_rx.sv
module mhp_serial_rx
  import mhp_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned BAUD   = 31_250,
  parameter int unsigned OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  output logic              byte_valid_o,
  output logic [MIDI_W-1:0] byte_o
);

  localparam int unsigned DIV  = baud_div(CLK_HZ, BAUD, OS);
  localparam int unsigned DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned TW   = $clog2(OS);
  localparam int unsigned BW   = $clog2(MIDI_W);
  localparam int unsigned HALF = OS / 2 - 1;
  localparam int unsigned LAST = OS - 1;

  rx_state_e         state_q;
  logic              rxd_m, rxd_s;
  logic [DW-1:0]     pre_q;
  logic [TW-1:0]     tcnt_q;
  logic [BW-1:0]     bit_q;
  logic [MIDI_W-1:0] shift_q;
  logic              valid_q;

  logic tick, start_mid, bit_end, stop_end;
  assign tick      = (pre_q == DW'(DIV - 1));
  assign start_mid = tick && (state_q == RX_START) && (tcnt_q == TW'(HALF));
  assign bit_end   = tick && (state_q == RX_DATA)  && (tcnt_q == TW'(LAST));
  assign stop_end  = tick && (state_q == RX_STOP)  && (tcnt_q == TW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd_i;
      rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      pre_q   <= '0;
      tcnt_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          pre_q  <= '0;
          tcnt_q <= '0;
          if (!rxd_s) state_q <= RX_START;
        end
        RX_WAIT: begin
          pre_q  <= '0;
          tcnt_q <= '0;
          if (rxd_s) state_q <= RX_IDLE;
        end
        default: begin
          if (tick) begin
            pre_q  <= '0;
            tcnt_q <= tcnt_q + 1'b1;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
          if (start_mid) begin
            tcnt_q <= '0;
            bit_q  <= '0;
            state_q <= rxd_s ? RX_IDLE : RX_DATA;
          end
          if (bit_end) begin
            tcnt_q  <= '0;
            shift_q <= {rxd_s, shift_q[MIDI_W-1:1]};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == BW'(MIDI_W - 1)) state_q <= RX_STOP;
          end
          if (stop_end) begin
            tcnt_q <= '0;
            if (rxd_s) begin
              state_q <= RX_IDLE;
              valid_q <= 1'b1;
            end else begin
              state_q <= RX_WAIT;
            end
          end
        end
      endcase
    end
  end

  assign byte_valid_o = valid_q;
  assign byte_o       = shift_q;

  // R7: a byte is only delivered after a high stop-bit sample.
  a_r7_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(rxd_s));

  // R7: a framing error never produces a byte on the following cycle.
  a_r7_wait_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_end && !rxd_s) |=> !valid_q);

endmodule

// File: rtl/mhp_syn_stream.sv
module mhp_syn_stream
  import mhp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_push,
  input  logic [MIDI_W-1:0] host_byte,
  input  logic              rx_push,
  input  logic [MIDI_W-1:0] rx_byte,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [MIDI_W-1:0] data_o,
  output logic              full_o
);

  logic              valid_q;
  logic [MIDI_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (!valid_q) begin
      if (host_push) begin
        valid_q <= 1'b1;
        data_q  <= host_byte;
      end else if (rx_push) begin
        valid_q <= 1'b1;
        data_q  <= rx_byte;
      end
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign full_o  = valid_q;

  // R11: an offered byte is held unchanged until accepted.
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));

  // R11: host byte wins a same-cycle race into an empty slot.
  a_r11_host_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && host_push && rx_push) |=> (data_q == $past(host_byte)));

endmodule

// File: rtl/mhp_host_regs.sv
module mhp_host_regs
  import mhp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_end,
  input  logic              wr_sel,
  input  logic [MIDI_W-1:0] wr_byte,
  input  logic              rd_end,
  input  logic              rd_sel,
  input  logic              rx_valid,
  input  logic [MIDI_W-1:0] rx_byte,
  input  logic              slot_full,
  output logic [MIDI_W-1:0] data_o,
  output logic [MIDI_W-1:0] status_o,
  output logic              avail_o,
  output logic              overrun_o,
  output logic              host_push,
  output logic              rx_to_syn
);

  logic              uart_q, avail_q, ovr_q;
  logic [MIDI_W-1:0] data_q;

  logic cmd_evt, cmd_reset, cmd_uart, ack_load, data_rd, rx_to_host;
  assign cmd_evt    = wr_end & wr_sel;
  assign cmd_reset  = cmd_evt & (wr_byte == CMD_RESET);
  assign cmd_uart   = cmd_evt & (wr_byte == CMD_UART) & ~uart_q;
  assign ack_load   = cmd_reset | cmd_uart;
  assign data_rd    = rd_end & ~rd_sel;
  assign rx_to_host = rx_valid & uart_q;
  assign rx_to_syn  = rx_valid & ~uart_q;
  assign host_push  = wr_end & ~wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uart_q  <= 1'b0;
      avail_q <= 1'b0;
      ovr_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (data_rd) avail_q <= 1'b0;
      if (rx_to_host) begin
        data_q  <= rx_byte;
        avail_q <= 1'b1;
        if (avail_q && !data_rd) ovr_q <= 1'b1;
      end
      if (cmd_reset) begin
        uart_q  <= 1'b0;
        ovr_q   <= 1'b0;
        data_q  <= ACK_BYTE;
        avail_q <= 1'b1;
      end
      if (cmd_uart) begin
        uart_q  <= 1'b1;
        data_q  <= ACK_BYTE;
        avail_q <= 1'b1;
      end
    end
  end

  assign data_o    = data_q;
  assign status_o  = status_byte(slot_full, avail_q);
  assign avail_o   = avail_q;
  assign overrun_o = ovr_q;

  // R6: a data read with nothing new arriving leaves the flag clear.
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_to_host && !ack_load) |=> !avail_q);

  // R5: UART mode is left only by the reset command.
  a_r5_uart_held: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_q && !cmd_reset) |=> uart_q);

  // R10: overrun is sticky until the reset command.
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !cmd_reset) |=> ovr_q);

  // R10: an unread byte overwritten in UART mode raises overrun.
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_to_host && avail_q && !data_rd && !cmd_reset) |=> ovr_q);

  // R8: the data register changes only by UART reception or acknowledge.
  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_to_host && !ack_load) |=> $stable(data_q));

endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import mhp_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned BAUD        = 31_250,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel_n,
  input  logic       bus_rd_n,
  input  logic       bus_wr_n,
  input  logic       bus_reg_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rdata_oe,
  output logic       host_int,
  input  logic       midi_rxd,
  output logic       syn_valid,
  output logic [7:0] syn_data,
  input  logic       syn_ready,
  output logic       rx_overrun
);

  localparam int unsigned WPAY = MIDI_W + 1;

  logic              wr_end, rd_end;
  logic [WPAY-1:0]   wr_pay;
  logic [0:0]        rd_pay;
  logic              rx_valid;
  logic [MIDI_W-1:0] rx_byte;
  logic              slot_full, host_push, rx_to_syn, avail;
  logic [MIDI_W-1:0] data_reg, status_reg;

  mhp_strobe_sync #(.STAGES(SYNC_STAGES), .W(WPAY)) u_wr_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (~bus_sel_n & ~bus_wr_n),
    .pay_i ({bus_reg_sel, bus_wdata}),
    .end_o (wr_end),
    .pay_o (wr_pay)
  );

  mhp_strobe_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rd_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (~bus_sel_n & ~bus_rd_n),
    .pay_i (bus_reg_sel),
    .end_o (rd_end),
    .pay_o (rd_pay)
  );

  mhp_serial_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OS(OVERSAMPLE)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxd_i        (midi_rxd),
    .byte_valid_o (rx_valid),
    .byte_o       (rx_byte)
  );

  mhp_host_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_end    (wr_end),
    .wr_sel    (wr_pay[MIDI_W]),
    .wr_byte   (wr_pay[MIDI_W-1:0]),
    .rd_end    (rd_end),
    .rd_sel    (rd_pay[0]),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .slot_full (slot_full),
    .data_o    (data_reg),
    .status_o  (status_reg),
    .avail_o   (avail),
    .overrun_o (rx_overrun),
    .host_push (host_push),
    .rx_to_syn (rx_to_syn)
  );

  mhp_syn_stream u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_push (host_push),
    .host_byte (wr_pay[MIDI_W-1:0]),
    .rx_push   (rx_to_syn),
    .rx_byte   (rx_byte),
    .ready_i   (syn_ready),
    .valid_o   (syn_valid),
    .data_o    (syn_data),
    .full_o    (slot_full)
  );

  assign bus_rdata    = bus_reg_sel ? status_reg : data_reg;
  assign bus_rdata_oe = ~bus_sel_n & ~bus_rd_n;
  assign host_int     = avail;

  // R9: the interrupt rises only with a received byte or a command acknowledge.
  a_r9_int_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_int) |-> $past(rx_valid || (wr_end && wr_pay[MIDI_W])));

endmodule

// File: tb/midi_host_port_tb.sv
module midi_host_port_tb;

  localparam int unsigned TB_CLK_HZ = 2_000_000;
  localparam int unsigned BIT_CLKS  = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_reg_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_rdata_oe, host_int, syn_valid, rx_overrun;
  logic       midi_rxd = 1'b1;
  logic [7:0] syn_data;
  logic       syn_ready = 1'b0;

  always #4 clk = ~clk;

  midi_host_port #(.CLK_HZ(TB_CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_reg_sel(bus_reg_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .host_int(host_int),
    .midi_rxd(midi_rxd), .syn_valid(syn_valid), .syn_data(syn_data),
    .syn_ready(syn_ready), .rx_overrun(rx_overrun)
  );

  // Behavioural reference state
  bit         m_uart, m_avail, m_ovr;
  logic [7:0] m_data;
  logic [7:0] m_q[$];
  int         checks = 0, errors = 0;
  bit         cmp_en = 1'b0, done = 1'b0;
  logic [7:0] rd_d;
  logic       rd_oe;

  function automatic logic [7:0] exp_status();
    return {m_q.size() != 0, !m_avail, 6'h3F};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Clock-by-clock comparison against the model during quiet periods
  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      chk("R9/R6 host_int", {7'd0, host_int}, {7'd0, m_avail});
      chk("R10 overrun", {7'd0, rx_overrun}, {7'd0, m_ovr});
      chk("R11 syn_valid", {7'd0, syn_valid}, {7'd0, m_q.size() != 0});
      if (m_q.size() != 0) chk("R11 syn_data", syn_data, m_q[0]);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input bit sel_on, input bit rs, input logic [7:0] d);
    cmp_en = 1'b0;
    @(negedge clk);
    bus_reg_sel = rs; bus_wdata = d; bus_sel_n = !sel_on; bus_wr_n = 1'b0;
    idle(4);
    bus_wr_n = 1'b1; bus_sel_n = 1'b1;
    idle(8);
    if (sel_on) begin
      if (!rs) begin
        if (m_q.size() == 0) m_q.push_back(d);
      end else if (d == 8'hFF) begin
        m_uart = 0; m_ovr = 0; m_data = 8'hFE; m_avail = 1;
      end else if (d == 8'h3F && !m_uart) begin
        m_uart = 1; m_data = 8'hFE; m_avail = 1;
      end
    end
    cmp_en = 1'b1;
  endtask

  task automatic bus_read(input bit sel_on, input bit rs);
    cmp_en = 1'b0;
    @(negedge clk);
    bus_reg_sel = rs; bus_sel_n = !sel_on; bus_rd_n = 1'b0;
    idle(3);
    rd_d = bus_rdata; rd_oe = bus_rdata_oe;
    bus_rd_n = 1'b1; bus_sel_n = 1'b1;
    idle(8);
    if (sel_on && !rs) m_avail = 0;
    cmp_en = 1'b1;
  endtask

  task automatic pop();
    cmp_en = 1'b0;
    @(negedge clk); syn_ready = 1'b1;
    @(negedge clk); syn_ready = 1'b0;
    if (m_q.size() != 0) void'(m_q.pop_front());
    cmp_en = 1'b1;
  endtask

  task automatic send_midi(input logic [7:0] b, input bit stop_ok);
    cmp_en = 1'b0;
    midi_rxd = 1'b0; idle(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin midi_rxd = b[i]; idle(BIT_CLKS); end
    midi_rxd = stop_ok; idle(BIT_CLKS);
    midi_rxd = 1'b1; idle(2 * BIT_CLKS);
    if (stop_ok) begin
      if (m_uart) begin
        if (m_avail) m_ovr = 1;
        m_data = b; m_avail = 1;
      end else if (m_q.size() == 0) m_q.push_back(b);
    end
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_uart = 0; m_avail = 0; m_ovr = 0; m_data = 8'h00;
    idle(5);
    rst_n = 1'b1;
    idle(3);
    cmp_en = 1'b1;

    // R1 reset state
    chk("R1 oe idle", {7'd0, bus_rdata_oe}, 8'd0);
    bus_read(1, 1);
    chk("R1 status after reset", rd_d, 8'h7F);
    chk("R2 oe during read", {7'd0, rd_oe}, 8'd1);
    bus_read(0, 1);
    chk("R2 oe without select", {7'd0, rd_oe}, 8'd0);

    // R3 / R11 host writes into stream
    bus_write(1, 0, 8'h90);
    chk("R3 stream byte", syn_data, 8'h90);
    bus_read(1, 1);
    chk("R11 status busy", rd_d, exp_status());
    bus_write(1, 0, 8'h45);
    pop();
    chk("R11 dropped write", {7'd0, syn_valid}, 8'd0);
    bus_write(0, 0, 8'h55);
    chk("R3 unselected write ignored", {7'd0, syn_valid}, 8'd0);

    // R8 / R7 reception in intelligent mode
    send_midi(8'hA5, 1);
    chk("R8 rx to stream", syn_data, 8'hA5);
    chk("R8 no interrupt", {7'd0, host_int}, 8'd0);
    pop();

    // R5 unknown command in intelligent mode
    bus_write(1, 1, 8'h12);
    chk("R5 unknown cmd ignored", {7'd0, host_int}, 8'd0);

    // R5 / R6 enter UART mode
    bus_write(1, 1, 8'h3F);
    chk("R5 ack interrupt", {7'd0, host_int}, 8'd1);
    bus_read(1, 1);
    chk("R6 status read keeps flag", rd_d, 8'h3F);
    chk("R6 int after status read", {7'd0, host_int}, 8'd1);
    bus_read(1, 0);
    chk("R5 ack byte", rd_d, 8'hFE);
    chk("R6 int cleared", {7'd0, host_int}, 8'd0);

    // R9 / R10 UART reception and overrun
    send_midi(8'h3C, 1);
    chk("R9 interrupt", {7'd0, host_int}, 8'd1);
    chk("R9 stream untouched", {7'd0, syn_valid}, 8'd0);
    send_midi(8'h81, 1);
    chk("R10 overrun set", {7'd0, rx_overrun}, 8'd1);
    bus_read(1, 0);
    chk("R10 newer byte kept", rd_d, 8'h81);
    chk("R10 overrun sticky", {7'd0, rx_overrun}, 8'd1);

    // R7 framing error and glitch
    send_midi(8'h66, 0);
    chk("R7 bad stop dropped", {7'd0, host_int}, 8'd0);
    cmp_en = 1'b0;
    midi_rxd = 1'b0; idle(3); midi_rxd = 1'b1; idle(2 * BIT_CLKS);
    cmp_en = 1'b1;
    chk("R7 glitch ignored", {7'd0, host_int}, 8'd0);

    // R5 commands ignored in UART mode; R3 data write still reaches stream
    bus_write(1, 1, 8'h3F);
    chk("R5 uart 3F ignored", {7'd0, host_int}, 8'd0);
    bus_write(1, 0, 8'h7E);
    chk("R3 uart data write", syn_data, 8'h7E);
    pop();

    // R4 reset command
    bus_write(1, 1, 8'hFF);
    chk("R4 overrun cleared", {7'd0, rx_overrun}, 8'd0);
    bus_read(1, 0);
    chk("R4 ack byte", rd_d, 8'hFE);
    send_midi(8'h24, 1);
    chk("R4 back to intelligent", syn_data, 8'h24);
    chk("R4 no interrupt", {7'd0, host_int}, 8'd0);

    // R11 serial byte dropped while slot occupied
    send_midi(8'h99, 1);
    pop();
    chk("R11 slot empty", {7'd0, syn_valid}, 8'd0);
    bus_read(1, 1);
    chk("R2 status final", rd_d, exp_status());

    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule